// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the loudness envelope for the four operators of one FM synthesis channel. Each operator holds a 10-bit attenuation, where 0 is full volume and 1023 is silence, and a five-valued phase register. A 16.16 fixed-point accumulator gains a programmable step on every audio sample. Each time the accumulator crosses three whole samples, one envelope tick is consumed, a shared tick counter advances, and every operator that is not idle may move one step along its curve.

Each operator has four packed rate words, one per active phase. The top byte of a rate word is a shift that sets how often the operator may move: it moves only on ticks where the low bits of the counter below that shift are all zero. The low 24 bits hold eight 3-bit step exponents. The counter bits just above the shift choose which of the eight is used. The attack curve is exponential and shrinks the attenuation toward zero. Decay, sustain and release add a linear step. Key-on and key-off are applied directly by the host. The block reports, for each operator, the attenuation plus a per-operator level offset, along with its phase and a one-cycle strobe for every step taken.

Top module: `fm_env_gen`

## Requirements
- R1: During and just after reset, every operator is in phase OFF (code 0) with attenuation 1023, so `env_lvl` equals 1023 plus that operator's `tot_lvl`, and no `op_step` bit is set.
- R2: A high `sample_en` adds `timer_step` to a 32-bit accumulator. In any cycle where the accumulator is at least 0x30000, one tick is taken: 0x30000 is subtracted and the 12-bit tick counter increments. At most one tick is taken per clock, so a backlog of N thresholds is drained over N consecutive cycles.
- R3: On a tick, an operator that is not OFF steps only when the incremented counter, ANDed with (1<<s)-1, is zero. Here s is bits 31:24 of the rate word for its current phase, and any s of 32 or more opens the gate only at counter value 0. Every step pulses that operator's `op_step` bit for exactly one cycle after the tick.
- R4: The step exponent e is the 3-bit field at bit 3*k of the rate word, where k = (counter >> s) & 7.
- R5: In ATTACK (code 4), the new attenuation is att + ((~att << e) >>> 5), using signed arithmetic. A result of 0 or below becomes 0 and moves the operator to DECAY (code 3).
- R6: In DECAY, the attenuation rises by (1<<e)>>1, saturating at 1023. Once it reaches or exceeds `sus_lvl`, the operator moves to SUSTAIN (code 2).
- R7: In SUSTAIN, the attenuation rises by (1<<e)>>1 and saturates at 1023. The phase never leaves SUSTAIN without a key event.
- R8: In RELEASE (code 1), the attenuation rises by (1<<e)>>1. When it reaches 1023, the operator moves to OFF.
- R9: A key-on bit forces ATTACK and a key-off bit forces RELEASE in the next cycle, keeping the current attenuation, with key-on winning. In the cycle a key bit is high, no step is taken for that operator.
- R10: `env_lvl` for each operator is the 11-bit sum of its attenuation and its 10-bit `tot_lvl`.
- R11: An operator in OFF ignores ticks. Its attenuation stays at 1023 and it never strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One audio sample has elapsed |
| timer_step | input | 32 | 16.16 amount added to the accumulator per sample |
| key_on | input | 4 | Per-operator key-on |
| key_off | input | 4 | Per-operator key-off |
| atk_rate | input | 128 | Attack rate word per operator, operator n in bits 32n+31:32n |
| dec_rate | input | 128 | Decay rate word per operator |
| sus_rate | input | 128 | Sustain rate word per operator |
| rel_rate | input | 128 | Release rate word per operator |
| sus_lvl | input | 40 | Decay-to-sustain attenuation, 10 bits per operator |
| tot_lvl | input | 40 | Attenuation offset added at the output, 10 bits per operator |
| env_lvl | output | 44 | Attenuation plus offset, 11 bits per operator |
| op_state | output | 12 | Phase per operator, 3 bits each (codes as in the requirements) |
| op_step | output | 4 | One-cycle strobe per operator step |

## Verification
The hardest case to reach from the ports is a tick backlog, where several envelope ticks are owed for a single sample and must be drained on back-to-back clocks. In steady running, every sample adds exactly one threshold, so no backlog forms. The stimulus therefore parks an operator in sustain with a shift of zero, so that it strobes on every tick. It then withholds samples until the accumulator falls below the threshold, and supplies a single sample worth three thresholds. The strobe then counts the ticks directly. A second operator with a rate shift of three confirms that only every eighth tick opens its gate.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;

  localparam int ATT_W   = 10;
  localparam int RATE_W  = 32;
  localparam int SH_LSB  = 24;
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  typedef enum logic [2:0] {
    EG_OFF = 3'd0,
    EG_REL = 3'd1,
    EG_SUS = 3'd2,
    EG_DEC = 3'd3,
    EG_ATK = 3'd4
  } eg_phase_t;

  // gate: true when the counter bits below the rate shift are all zero
  function automatic logic gate_open(input logic [RATE_W-1:0] rate, input logic [31:0] cnt);
    logic [7:0]  sh;
    logic [31:0] mask;
    sh   = rate[RATE_W-1:SH_LSB];
    mask = (sh >= 8'd32) ? 32'hFFFF_FFFF : ((32'd1 << sh) - 32'd1);
    return (cnt & mask) == 32'd0;
  endfunction

  // exponent: 3-bit field picked by the counter bits above the shift
  function automatic logic [2:0] pick_exp(input logic [RATE_W-1:0] rate, input logic [31:0] cnt);
    logic [7:0]  sh;
    logic [31:0] upper;
    int          k;
    sh    = rate[RATE_W-1:SH_LSB];
    upper = (sh >= 8'd32) ? 32'd0 : (cnt >> sh);
    k     = int'(upper[2:0]);
    return rate[k*3 +: 3];
  endfunction

  // exponential attack: signed sum, caller clamps at zero
  function automatic logic signed [31:0] attack_sum(input logic [ATT_W-1:0] att, input logic [2:0] e);
    logic signed [31:0] cur;
    logic signed [31:0] inv;
    cur = $signed({{(32-ATT_W){1'b0}}, att});
    inv = ~cur;
    return cur + ((inv <<< e) >>> 5);
  endfunction

  // linear rise with saturation at the maximum attenuation
  function automatic logic [ATT_W-1:0] rise_sat(input logic [ATT_W-1:0] att, input logic [2:0] e);
    logic [31:0] s;
    s = {{(32-ATT_W){1'b0}}, att} + ((32'd1 << e) >> 1);
    return (s >= {{(32-ATT_W){1'b0}}, ATT_MAX}) ? ATT_MAX : s[ATT_W-1:0];
  endfunction

endpackage

// File: rtl/fm_env_timer.sv
module fm_env_timer #(
  parameter int TIMER_W      = 32,
  parameter int CNT_W        = 12,
  parameter int FRAC_W       = 16,
  parameter int TICK_SAMPLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [TIMER_W-1:0] timer_step,
  output logic               tick,
  output logic [CNT_W-1:0]   cnt_next
);

  localparam logic [TIMER_W-1:0] THRESH = TIMER_W'(TICK_SAMPLES) << FRAC_W;

  logic [TIMER_W-1:0] acc;
  logic [CNT_W-1:0]   cnt;

  assign tick     = (acc >= THRESH);
  assign cnt_next = cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= acc - (tick ? THRESH : '0) + (sample_en ? timer_step : '0);
      if (tick) cnt <= cnt_next;
    end
  end

  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R2
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R2
  AST_BACKLOG_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sample_en) |=> (acc < $past(acc))); // R2

endmodule

// File: rtl/fm_env_op.sv
module fm_env_op
  import fm_env_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              key_on,
  input  logic              key_off,
  input  logic [RATE_W-1:0] atk_word,
  input  logic [RATE_W-1:0] dec_word,
  input  logic [RATE_W-1:0] sus_word,
  input  logic [RATE_W-1:0] rel_word,
  input  logic [ATT_W-1:0]  sus_lvl,
  output logic [ATT_W-1:0]  att,
  output eg_phase_t         phase,
  output logic              step
);

  logic [RATE_W-1:0]  cur_word;
  logic [31:0]        cnt_w;
  logic               gate;
  logic [2:0]         ex;
  logic signed [31:0] atk_s;
  logic [ATT_W-1:0]   rise;
  logic [ATT_W-1:0]   att_nx;
  eg_phase_t          phase_nx;
  logic               do_step;

  assign cnt_w = 32'(cnt);

  always_comb begin
    unique case (phase)
      EG_ATK:  cur_word = atk_word;
      EG_DEC:  cur_word = dec_word;
      EG_SUS:  cur_word = sus_word;
      default: cur_word = rel_word;
    endcase
  end

  assign gate    = gate_open(cur_word, cnt_w);
  assign ex      = pick_exp(cur_word, cnt_w);
  assign atk_s   = attack_sum(att, ex);
  assign rise    = rise_sat(att, ex);
  assign do_step = tick && gate && (phase != EG_OFF) && !key_on && !key_off;

  always_comb begin
    att_nx   = att;
    phase_nx = phase;
    unique case (phase)
      EG_ATK: begin
        if (atk_s <= 0) begin
          att_nx   = '0;
          phase_nx = EG_DEC;
        end else begin
          att_nx = atk_s[ATT_W-1:0];
        end
      end
      EG_DEC: begin
        att_nx = rise;
        if (rise >= sus_lvl) phase_nx = EG_SUS;
      end
      EG_SUS: att_nx = rise;
      EG_REL: begin
        att_nx = rise;
        if (rise == ATT_MAX) phase_nx = EG_OFF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att   <= ATT_MAX;
      phase <= EG_OFF;
      step  <= 1'b0;
    end else begin
      step <= do_step;
      if (key_on)       phase <= EG_ATK;
      else if (key_off) phase <= EG_REL;
      else if (do_step) begin
        att   <= att_nx;
        phase <= phase_nx;
      end
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == EG_OFF) |-> (att == ATT_MAX)); // R11
  AST_KEYON_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (phase == EG_ATK)); // R9
  AST_KEYOFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off && !key_on) |=> (phase == EG_REL)); // R9
  AST_ATTACK_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == EG_ATK && !key_on && !key_off) |=> (phase != EG_DEC || att == '0)); // R5
  AST_RELEASE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == EG_REL && !key_on && !key_off) |=> (att >= $past(att))); // R8
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !step); // R3

endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
  import fm_env_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int TIMER_W = 32,
  parameter int CNT_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_en,
  input  logic [TIMER_W-1:0]       timer_step,
  input  logic [NUM_OPS-1:0]       key_on,
  input  logic [NUM_OPS-1:0]       key_off,
  input  logic [NUM_OPS*32-1:0]    atk_rate,
  input  logic [NUM_OPS*32-1:0]    dec_rate,
  input  logic [NUM_OPS*32-1:0]    sus_rate,
  input  logic [NUM_OPS*32-1:0]    rel_rate,
  input  logic [NUM_OPS*10-1:0]    sus_lvl,
  input  logic [NUM_OPS*10-1:0]    tot_lvl,
  output logic [NUM_OPS*11-1:0]    env_lvl,
  output logic [NUM_OPS*3-1:0]     op_state,
  output logic [NUM_OPS-1:0]       op_step
);

  localparam int ENV_W = ATT_W + 1;

  logic             tick;
  logic [CNT_W-1:0] cnt_next;

  fm_env_timer #(
    .TIMER_W(TIMER_W),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .timer_step(timer_step),
    .tick      (tick),
    .cnt_next  (cnt_next)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic [ATT_W-1:0] att;
    eg_phase_t        phase;

    fm_env_op #(.CNT_W(CNT_W)) u_op (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt     (cnt_next),
      .key_on  (key_on[g]),
      .key_off (key_off[g]),
      .atk_word(atk_rate[g*32 +: 32]),
      .dec_word(dec_rate[g*32 +: 32]),
      .sus_word(sus_rate[g*32 +: 32]),
      .rel_word(rel_rate[g*32 +: 32]),
      .sus_lvl (sus_lvl[g*ATT_W +: ATT_W]),
      .att     (att),
      .phase   (phase),
      .step    (op_step[g])
    );

    assign env_lvl[g*ENV_W +: ENV_W] = ENV_W'(att) + ENV_W'(tot_lvl[g*ATT_W +: ATT_W]);
    assign op_state[g*3 +: 3]        = phase;
  end

endmodule

// File: tb/fm_env_gen_test.sv
module fm_env_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int THR = 3 << 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_en = 1'b0;
  logic [31:0]   timer_step = '0;
  logic [N-1:0]  key_on = '0;
  logic [N-1:0]  key_off = '0;
  logic [127:0]  atk_rate, dec_rate, sus_rate, rel_rate;
  logic [39:0]   sus_lvl, tot_lvl;
  logic [43:0]   env_lvl;
  logic [11:0]   op_state;
  logic [N-1:0]  op_step;

  fm_env_gen uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .timer_step(timer_step),
    .key_on(key_on), .key_off(key_off), .atk_rate(atk_rate), .dec_rate(dec_rate),
    .sus_rate(sus_rate), .rel_rate(rel_rate), .sus_lvl(sus_lvl), .tot_lvl(tot_lvl),
    .env_lvl(env_lvl), .op_state(op_state), .op_step(op_step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // behavioural reference
  longint m_acc;
  int     m_cnt;
  int     m_att [N];
  int     m_ph  [N];
  bit     m_stp [N];

  function automatic int word_of(int op, int ph);
    logic [127:0] v;
    case (ph)
      4: v = atk_rate;
      3: v = dec_rate;
      2: v = sus_rate;
      default: v = rel_rate;
    endcase
    return int'(v[op*32 +: 32]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0;
      for (int i = 0; i < N; i++) begin m_att[i] = 1023; m_ph[i] = 0; m_stp[i] = 0; end
    end else begin
      bit ticked;
      ticked = (m_acc >= THR);
      if (ticked) m_cnt = (m_cnt + 1) % 4096;
      m_acc = m_acc - (ticked ? THR : 0) + (sample_en ? longint'(timer_step) : 0);
      for (int i = 0; i < N; i++) begin
        m_stp[i] = 0;
        if (key_on[i]) m_ph[i] = 4;
        else if (key_off[i]) m_ph[i] = 1;
        else if (ticked && m_ph[i] != 0) begin
          int w, s, k, e, a, inc;
          bit open;
          w = word_of(i, m_ph[i]);
          s = (w >> 24) & 255;
          open = (s >= 32) ? (m_cnt == 0) : ((longint'(m_cnt) % (longint'(1) << s)) == 0);
          k = (s >= 32) ? 0 : ((m_cnt >> s) % 8);
          e = (w >> (3 * k)) & 7;
          inc = (1 << e) / 2;
          if (open) begin
            m_stp[i] = 1;
            case (m_ph[i])
              4: begin
                a = m_att[i] - (((m_att[i] + 1) * (1 << e) + 31) / 32);
                if (a <= 0) begin a = 0; m_ph[i] = 3; end
              end
              3: begin
                a = (m_att[i] + inc > 1023) ? 1023 : m_att[i] + inc;
                if (a >= int'(sus_lvl[i*10 +: 10])) m_ph[i] = 2;
              end
              2: a = (m_att[i] + inc > 1023) ? 1023 : m_att[i] + inc;
              default: begin
                a = (m_att[i] + inc > 1023) ? 1023 : m_att[i] + inc;
                if (a == 1023) m_ph[i] = 0;
              end
            endcase
            m_att[i] = a;
          end
        end
      end
    end
  end

  function automatic int env_of(int i);  return int'(env_lvl[i*11 +: 11]); endfunction
  function automatic int ph_of(int i);   return int'(op_state[i*3 +: 3]);  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison; env mismatches cover R4 R5 R6 R7 R8 R10
  task automatic compare_all();
    for (int i = 0; i < N; i++) begin
      int want;
      want = m_att[i] + int'(tot_lvl[i*10 +: 10]);
      check(env_of(i) == want, "R10 env (R4 R5 R6 R7 R8)", env_of(i), want);
      check(ph_of(i) == m_ph[i], "R9 phase", ph_of(i), m_ph[i]);
      check(op_step[i] == m_stp[i], "R3 strobe", int'(op_step[i]), int'(m_stp[i]));
    end
  endtask

  bit saw_dec0 = 0, saw_sus0 = 0, off1 = 0;
  int steps3 = 0, win = 0;

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      if (ph_of(0) == 3 && !saw_dec0) begin
        saw_dec0 = 1;
        check(env_of(0) == 5, "R5 decay entered at zero", env_of(0), 5);
      end
      if (ph_of(0) == 2 && !saw_sus0) begin
        saw_sus0 = 1;
        check(env_of(0) - 5 >= 300, "R6 sustain at level", env_of(0) - 5, 300);
      end
      if (ph_of(1) == 0) off1 = 1;
      check(env_of(2) == 2046 && op_step[2] == 0, "R11 idle operator", env_of(2), 2046);
      if (win > 0) begin
        win--;
        if (op_step[3]) steps3++;
      end
      key_on  = '0;
      key_off = '0;
    end
  endtask

  function automatic logic [31:0] mk(int sh, int e0, int e1);
    logic [31:0] w;
    w = '0;
    w[31:24] = 8'(sh);
    for (int k = 0; k < 8; k++) w[k*3 +: 3] = 3'((k % 2 == 0) ? e0 + k / 2 : e1);
    return w;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      atk_rate[i*32 +: 32] = mk(0, 1, 7);
      dec_rate[i*32 +: 32] = mk(1, 2, 3);
      sus_rate[i*32 +: 32] = mk(0, 6, 6);
      rel_rate[i*32 +: 32] = mk(0, 4, 7);
    end
    atk_rate[3*32 +: 32] = mk(3, 4, 4);
    dec_rate[3*32 +: 32] = mk(3, 4, 4);
    sus_lvl = {10'd1023, 10'd1023, 10'd500, 10'd300};
    tot_lvl = {10'd0, 10'd1023, 10'd100, 10'd5};

    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      check(env_of(i) == 1023 + int'(tot_lvl[i*10 +: 10]), "R1 reset level", env_of(i), 1023 + int'(tot_lvl[i*10 +: 10]));
      check(ph_of(i) == 0 && op_step[i] == 0, "R1 reset phase", ph_of(i), 0);
    end
    rst_n = 1'b1;
    run(2);

    sample_en  = 1'b1;
    timer_step = 32'(THR);
    key_on     = 4'b1011;
    run(1);
    check(ph_of(0) == 4 && ph_of(3) == 4, "R9 key-on to attack", ph_of(0), 4);
    run(4);
    key_off = 4'b0010;
    run(1);
    check(ph_of(1) == 1, "R9 key-off to release", ph_of(1), 1);
    run(60);
    win = 80;
    run(340);
    check(steps3 == 10, "R3 shift three gates 1 in 8", steps3, 10);
    check(saw_dec0 == 1, "R5 attack reached decay", int'(saw_dec0), 1);
    check(saw_sus0 == 1, "R6 decay reached sustain", int'(saw_sus0), 1);
    check(ph_of(0) == 2 && env_of(0) == 1028, "R7 sustain saturates", env_of(0), 1028);
    check(off1 == 1, "R8 release reached off", int'(off1), 1);

    // tick backlog: withhold samples, then one sample worth three ticks
    sample_en = 1'b0;
    run(6);
    begin
      int burst;
      burst = 0;
      sample_en  = 1'b1;
      timer_step = 32'(3 * THR);
      run(1);
      sample_en = 1'b0;
      for (int c = 0; c < 8; c++) begin
        run(1);
        if (op_step[0]) burst++;
      end
      check(burst == 3, "R2 backlog drained one tick per cycle", burst, 3);
    end

    sample_en  = 1'b1;
    timer_step = 32'(THR);
    key_off    = 4'b0001;
    run(1);
    check(ph_of(0) == 1, "R9 key-off from sustain", ph_of(0), 1);
    run(40);
    check(ph_of(0) == 0 && env_of(0) == 1028, "R8 release ends off", ph_of(0), 0);

    key_on = 4'b0001; key_off = 4'b0001;
    run(1);
    check(ph_of(0) == 4, "R9 key-on wins", ph_of(0), 4);
    run(30);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule